// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block takes one free-running source clock and produces a set of gated copies of it. An asynchronous, active-low stop request parks all gated copies together. A separate static enable bit for each copy can switch off that copy alone. A plain, ungated copy of the source is also brought out, and it keeps toggling whatever the stop request or the enables do.

The stop request first passes through a synchronizer in the source clock domain. A three-state machine then decides when gating may change: PARK, WINDOW and RUN. For each output, a falling-edge register captures the machine's run decision together with the static enable, and that register is ANDed with the clock. Gating can therefore only change while the clock is low. A parked output sits low, and every high phase that is delivered has full width.

A mode parameter selects one of two variants. The CPU variant has two synchronizer stages and a minimum run of 100 cycles. The PCI variant has one synchronizer stage and a minimum run of 10 cycles. The state machine behaves as follows:

- PARK --release--> WINDOW: the synchronized request is seen released, and the counter clears.
- WINDOW --expire_run--> RUN: the minimum run has elapsed and the request is released.
- WINDOW --expire_park--> PARK: the minimum run has elapsed and the request is still asserted.
- RUN --stop--> PARK: the synchronized request is seen asserted.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is held, every gated output is low and `parked` is 1. After reset is released, the block behaves as if a release of the stop request were first sampled on the first rising edge. The first gated pulse therefore comes on rising edge SYNC+2, where SYNC is 2 in CPU mode and 1 in PCI mode.
- R2: A parked output stays low for whole cycles. The pulse that starts on the rising edge where the block enters PARK is delivered complete.
- R3: Every high phase on a gated output starts on a rising edge of the source and lasts exactly half a source period.
- R4: CPU mode, running outside the minimum-run window. Let edge k be the first rising edge that samples the request low. Edges k, k+1 and k+2 still give pulses, no pulse is given from k+3 on, and `parked` reads 1 from edge k+2.
- R5: CPU mode, release. Let edge k be the first rising edge that samples the request high. Edges k to k+2 give no pulse, the first pulse comes at k+3, and `parked` reads 0 from edge k+2.
- R6: Let e be the edge where the block leaves PARK. Once it has left PARK, it delivers at least MIN_RUN pulses, with MIN_RUN equal to 100 in CPU mode and 10 in PCI mode. A stop that is still asserted when the window ends is applied at edge e+MIN_RUN: that edge still gives a pulse and the next one gives none.
- R7: A stop request that is asserted and then released inside the minimum-run window is dropped, and the clock keeps running after the window.
- R8: PCI mode. A stop first sampled at edge k while in RUN leaves pulses at k and k+1 and none from k+2 on. A release first sampled at edge k gives its first pulse at k+2.
- R9: `clk_free` follows the source clock at all times, whatever the stop request and the enables are.
- R10: When `out_en[i]` goes to 0 during a high phase, output i completes that pulse and stays low from the next falling edge. When it returns to 1 while the block is not parked, the output resumes on the next rising edge. The other outputs are not affected.
- R11: `parked` is 1 exactly while the machine is in PARK. While the synchronized request stays asserted, the machine does not leave PARK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| out_en | input | N_OUT | Static enable for each gated output, 1 = allowed to run |
| clk_gated | output | N_OUT | Gated clock outputs |
| clk_free | output | 1 | Ungated copy of the source clock |
| parked | output | 1 | 1 while the gated outputs are held stopped |

## Verification
The main function is exercised with four stop-request patterns:

- A stop asserted inside the minimum-run window. This tells a correctly deferred stop apart from an early one.
- A short stop pulse inside the window. This tells level sampling apart from a latched request.
- A stop asserted during free running. This measures the exact off latency.
- A release. This measures the on latency.

Both the two-stage CPU variant and the one-stage PCI variant run side by side, so an off-by-one in either synchronizer depth shows up as a pulse one edge early or late. A static enable is dropped and restored in the middle of a high phase; this shows whether the enable is captured at the falling edge or applied combinationally. Every gated pulse is also timed, to catch truncated or zero-width highs.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;

    // gating state machine
    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_RUN    = 2'd2
    } gate_state_e;

    // variant selection
    typedef enum logic {
        GATE_CPU = 1'b0,
        GATE_PCI = 1'b1
    } gate_mode_e;

    function automatic int sync_depth(gate_mode_e m);
        return (m == GATE_PCI) ? 1 : 2;
    endfunction

    function automatic int min_run_cycles(gate_mode_e m);
        return (m == GATE_PCI) ? 10 : 100;
    endfunction

endpackage

// File: rtl/csg_sync.sv
`timescale 1ns/1ps
module csg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    // reset value 0 = request asserted, so startup looks like a release
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/csg_fsm.sv
`timescale 1ns/1ps
module csg_fsm
    import csg_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_sync_n,
    output logic run_o,
    output logic parked_o
);
    localparam int CNT_W = $clog2(MIN_RUN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RUN - 1);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RUN);

    gate_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PARK: begin
                if (stop_sync_n) begin
                    state_d = ST_WINDOW;
                    cnt_d   = '0;
                end
            end
            ST_WINDOW: begin
                if (cnt_q == LAST) begin
                    state_d = stop_sync_n ? ST_RUN : ST_PARK;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (!stop_sync_n) state_d = ST_PARK;
            end
            default: begin
                state_d = ST_PARK;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        run_o    = (state_q != ST_PARK);
        parked_o = (state_q == ST_PARK);
    end

    // checker-only count of edges since PARK was left, saturating
    logic [CNT_W-1:0] chk_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   chk_run_q <= '0;
        else if (state_q == ST_PARK)  chk_run_q <= '0;
        else if (chk_run_q != FLOOR)  chk_run_q <= chk_run_q + 1'b1;
    end

    // R6: parking only after the minimum run
    a_r6_run_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parked_o) |-> (chk_run_q == FLOOR));

    // R4 / R8: a synchronized stop in RUN parks on the next edge
    a_r4_stop_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stop_sync_n) |=> parked_o);

    // R7: running with no stop keeps running
    a_r7_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_sync_n) |=> !parked_o);

    // R11: held stop keeps the block parked
    a_r11_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (parked_o && !stop_sync_n) |=> parked_o);

endmodule

// File: rtl/csg_gate.sv
`timescale 1ns/1ps
module csg_gate #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [N_OUT-1:0] en_cfg,
    output logic [N_OUT-1:0] clk_o
);
    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            logic en_q;

            // enable changes only while the clock is low
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= run_i & en_cfg[i];
            end

            assign clk_o[i] = clk & en_q;

            // R2: no run decision at the last falling edge -> high phase is dark
            a_r2_park_low: assert property (@(negedge clk) disable iff (!rst_n)
                !$past(run_i) |-> !clk_o[i]);

            // R10: disabled lane stays dark
            a_r10_cfg_low: assert property (@(negedge clk) disable iff (!rst_n)
                !$past(en_cfg[i]) |-> !clk_o[i]);
        end
    endgenerate

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter csg_pkg::gate_mode_e MODE = csg_pkg::GATE_CPU,
    parameter int N_OUT = 2
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_gated,
    output logic             clk_free,
    output logic             parked
);
    localparam int SYNC_STAGES = csg_pkg::sync_depth(MODE);
    localparam int MIN_RUN     = csg_pkg::min_run_cycles(MODE);

    logic stop_sync_n;
    logic run_now;

    csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .async_n (stop_req_n),
        .sync_n  (stop_sync_n)
    );

    csg_fsm #(.MIN_RUN(MIN_RUN)) u_fsm (
        .clk         (clk_src),
        .rst_n       (rst_n),
        .stop_sync_n (stop_sync_n),
        .run_o       (run_now),
        .parked_o    (parked)
    );

    csg_gate #(.N_OUT(N_OUT)) u_gate (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .run_i  (run_now),
        .en_cfg (out_en),
        .clk_o  (clk_gated)
    );

    // R9: ungated copy
    assign clk_free = clk_src;

endmodule

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;
    import csg_pkg::*;

    localparam int HALF = 4; // 125 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_stop_n = 1'b1;
    logic       pci_stop_n = 1'b1;
    logic [1:0] cpu_en = 2'b11;
    logic [0:0] pci_en = 1'b1;
    logic [1:0] cpu_clk;
    logic       cpu_free, cpu_parked;
    logic [0:0] pci_clk;
    logic       pci_free, pci_parked;

    always #HALF clk = ~clk;

    clk_stop_gate #(.MODE(GATE_CPU), .N_OUT(2)) uut (
        .clk_src(clk), .rst_n(rst_n), .stop_req_n(cpu_stop_n), .out_en(cpu_en),
        .clk_gated(cpu_clk), .clk_free(cpu_free), .parked(cpu_parked)
    );

    clk_stop_gate #(.MODE(GATE_PCI), .N_OUT(1)) uut_pci (
        .clk_src(clk), .rst_n(rst_n), .stop_req_n(pci_stop_n), .out_en(pci_en),
        .clk_gated(pci_clk), .clk_free(pci_free), .parked(pci_parked)
    );

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;

    // sig: 0 cpu lane0, 1 cpu lane1, 2 cpu free, 3 cpu parked, 4 pci lane0, 5 pci parked
    function automatic bit probe(int sig);
        case (sig)
            0: return cpu_clk[0];
            1: return cpu_clk[1];
            2: return cpu_free;
            3: return cpu_parked;
            4: return pci_clk[0];
            5: return pci_parked;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    task automatic expect_at(int c, int sig, bit v, string tag);
        sb_q.push_back('{c, sig, v, tag});
    endtask

    task automatic at_cycle(int n);
        wait (cyc == n);
        #1;
    endtask

    // monitor: sample mid high phase, pop and compare
    always @(posedge clk) begin
        if (rst_n) begin
            #2;
            cyc = cyc + 1;
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc == cyc) begin
                    check(sb_q[i].tag, int'(probe(sb_q[i].sig)), int'(sb_q[i].val));
                    sb_q.delete(i);
                end
            end
        end
    end

    // R3: pulse width and alignment
    time t_cpu_rise = 0;
    time t_pci_rise = 0;
    int  pulses = 0;
    int  bad_pulses = 0;

    always @(posedge cpu_clk[0]) if (rst_n) begin
        t_cpu_rise = $time;
        if (!clk) bad_pulses++;
    end
    always @(negedge cpu_clk[0]) if (rst_n) begin
        pulses++;
        if ($time - t_cpu_rise != HALF) bad_pulses++;
    end
    always @(posedge pci_clk[0]) if (rst_n) begin
        t_pci_rise = $time;
        if (!clk) bad_pulses++;
    end
    always @(negedge pci_clk[0]) if (rst_n) begin
        pulses++;
        if ($time - t_pci_rise != HALF) bad_pulses++;
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic cpu_flow();
        at_cycle(9);   cpu_stop_n = 1'b0;        // stop inside window
        expect_at(102, 0, 1'b1, "R6 pulse before window end");
        expect_at(102, 3, 1'b0, "R6 not parked in window");
        expect_at(103, 0, 1'b1, "R6 pulse on parking edge");
        expect_at(103, 3, 1'b1, "R11 parked flag");
        expect_at(104, 0, 1'b0, "R6 parked after window");
        expect_at(104, 1, 1'b0, "R2 lane1 parked");
        expect_at(104, 2, 1'b1, "R9 free runs while parked");
        expect_at(110, 0, 1'b0, "R2 stays low");
        at_cycle(109); cpu_stop_n = 1'b1;        // release, k=110
        expect_at(111, 3, 1'b1, "R11 still parked");
        expect_at(112, 0, 1'b0, "R5 no pulse k+2");
        expect_at(112, 3, 1'b0, "R5 flag clear k+2");
        expect_at(113, 0, 1'b1, "R5 first pulse k+3");
        at_cycle(119); cpu_stop_n = 1'b0;        // short stop in window
        at_cycle(129); cpu_stop_n = 1'b1;
        expect_at(212, 0, 1'b1, "R7 window end");
        expect_at(213, 0, 1'b1, "R7 dropped stop");
        expect_at(213, 3, 1'b0, "R7 not parked");
        expect_at(250, 0, 1'b1, "R7 still running");
        at_cycle(259); cpu_stop_n = 1'b0;        // stop in RUN, k=260
        expect_at(261, 3, 1'b0, "R4 flag before k+2");
        expect_at(261, 0, 1'b1, "R4 pulse k+1");
        expect_at(262, 0, 1'b1, "R4 pulse k+2");
        expect_at(262, 3, 1'b1, "R4 flag at k+2");
        expect_at(263, 0, 1'b0, "R4 dark at k+3");
        expect_at(263, 1, 1'b0, "R4 lane1 dark");
        expect_at(263, 2, 1'b1, "R9 free runs");
        expect_at(280, 0, 1'b0, "R2 held low");
        at_cycle(299); cpu_stop_n = 1'b1;        // release, k=300
        expect_at(302, 0, 1'b0, "R5 dark k+2");
        expect_at(303, 0, 1'b1, "R5 pulse k+3");
        expect_at(303, 1, 1'b1, "R5 lane1 pulse");
        expect_at(310, 1, 1'b1, "R10 lane1 before disable");
        expect_at(320, 1, 1'b0, "R10 lane1 still off");
        at_cycle(310); cpu_en[1] = 1'b0;         // mid high phase
        expect_at(311, 1, 1'b0, "R10 lane1 off next cycle");
        expect_at(311, 0, 1'b1, "R10 lane0 unaffected");
        expect_at(315, 1, 1'b0, "R10 lane1 held off");
        at_cycle(320); cpu_en[1] = 1'b1;
        expect_at(321, 1, 1'b1, "R10 lane1 resumes");
    endtask

    task automatic pci_flow();
        at_cycle(5);  pci_stop_n = 1'b0;         // in window (ends 12)
        expect_at(11, 4, 1'b1, "R8 pulse in window");
        expect_at(12, 4, 1'b1, "R8 pulse at window end");
        expect_at(12, 5, 1'b1, "R8 parked at window end");
        expect_at(13, 4, 1'b0, "R8 dark after window");
        at_cycle(20); pci_stop_n = 1'b1;         // k=21
        expect_at(21, 4, 1'b0, "R8 dark at k");
        expect_at(22, 4, 1'b0, "R8 dark at k+1");
        expect_at(22, 5, 1'b0, "R8 flag clear");
        expect_at(23, 4, 1'b1, "R8 first pulse k+2");
        at_cycle(40); pci_stop_n = 1'b0;         // k=41, in RUN
        expect_at(42, 4, 1'b1, "R8 pulse k+1");
        expect_at(42, 5, 1'b1, "R8 parked k+1");
        expect_at(43, 4, 1'b0, "R8 dark k+2");
        at_cycle(50); pci_stop_n = 1'b1;         // k=51
        expect_at(52, 4, 1'b0, "R8 dark before restart");
        expect_at(53, 4, 1'b1, "R8 restart pulse");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 cpu lanes low in reset", int'(cpu_clk), 0);
        check("R1 cpu parked in reset", int'(cpu_parked), 1);
        check("R1 pci lane low in reset", int'(pci_clk), 0);
        check("R1 pci parked in reset", int'(pci_parked), 1);
        expect_at(2, 3, 1'b1, "R1 cpu parked after release");
        expect_at(2, 0, 1'b0, "R1 cpu dark");
        expect_at(3, 0, 1'b0, "R1 cpu dark");
        expect_at(3, 3, 1'b0, "R1 cpu flag clear");
        expect_at(4, 0, 1'b1, "R1 cpu first pulse");
        expect_at(4, 1, 1'b1, "R1 cpu lane1 first pulse");
        expect_at(4, 2, 1'b1, "R9 free high");
        expect_at(1, 5, 1'b1, "R1 pci parked");
        expect_at(2, 4, 1'b0, "R1 pci dark");
        expect_at(2, 5, 1'b0, "R1 pci flag clear");
        expect_at(3, 4, 1'b1, "R1 pci first pulse");
        @(negedge clk);
        rst_n = 1'b1;
        fork
            cpu_flow();
            pci_flow();
        join
        at_cycle(460);
        check("R1 all expectations consumed", sb_q.size(), 0);
        check("R3 pulses seen", int'(pulses > 300), 1);
        check("R3 full-width pulses", bad_pulses, 0);
        finish_run();
    end

    initial begin
        #(64'd1600000);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual cycle %0d expected 460", cyc);
        finish_run();
    end

endmodule